// File: doc/BRIEF.md
# Progressive-Scan Pixel Readout Sequencer

This block generates the digital readout timing of a monochrome megapixel image sensor. It walks the pixel array one row at a time, left to right and top to bottom. For each row it produces a pixel stream framed by a frame-valid strobe and a line-valid strobe. No analog path exists. Each pixel word comes from a deterministic test pattern built from the pixel's physical row and column address. That makes the readout order visible on the data bus.

Configuration arrives on plain input ports rather than through a register bus:
- the horizontal blanking length, in cycles;
- the vertical blanking length, in rows;
- a column-skip readout that halves the pixels per line;
- a snapshot mode, in which the sequencer parks at the frame start and waits for a trigger before it reads out one frame.

A receiver samples the outputs on the falling clock edge, because they all change on the rising edge. The default geometry has 1,280 by 1,024 active pixels, offset by 16 dark columns and 8 dark rows.

Top module: `sensor_readout_gen`

## Requirements
- R1: A synchronous active-high reset forces frame_valid, line_valid and pix_data to zero at the next rising edge. Readout then restarts at the first row of vertical blanking. The first line_valid high appears in the output sampled after rising edge number VB*RT+1 following the release of reset, where VB and RT are defined in R2 and R3.
- R2: A row lasts RT = AO + HB clock cycles.
  - AO is the number of pixels output per line (see R4).
  - HB is the hblank input, with 0 treated as 1.
- R3: A frame lasts ACT_ROWS + VB rows.
  - VB is the vblank input, with 0 treated as 1.
  - The first VB rows of a frame are blank.
- R4: In each active row, line_valid is high for the first AO cycles and low for the rest of the row. AO is ACT_COLS in normal readout and ACT_COLS/2 when col_skip is 1.
- R5: frame_valid rises with the first pixel of the first active row. It stays high until the last pixel of the last active row, including the blanking between active rows. line_valid is never high while frame_valid is low.
- R6: While line_valid is high, pix_data equals (DARK_ROWS + a + DARK_COLS + c) modulo 2^PIX_W.
  - a is the active row index, counted from 0.
  - c is the column offset given by R7.
  - pix_data is 0 whenever line_valid is low.
- R7: For output pixel j within a line, the column offset c is j in normal readout. With col_skip set, c is 4*(j/2) + (j mod 2), so pairs of columns alternate between read and skipped.
- R8: In snapshot mode (snap_mode = 1), the sequencer holds at the frame start with both strobes low while trigger is low.
  - trigger high at a rising edge in that waiting state starts exactly one frame.
  - trigger is ignored at any other time.
- R9: With snap_mode = 0, frames follow each other back to back without a gap.
- R10: hblank, vblank and col_skip are captured only at the frame start. A change made during a frame affects only the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hblank | input | HB_W | Horizontal blanking cycles per row (0 acts as 1) |
| vblank | input | VB_W | Vertical blanking rows per frame (0 acts as 1) |
| col_skip | input | 1 | 1 selects the pair-skipping column readout |
| snap_mode | input | 1 | 1 selects triggered single-frame readout |
| trigger | input | 1 | Starts a frame while waiting in snapshot mode |
| frame_valid | output | 1 | High across the active rows of a frame |
| line_valid | output | 1 | High while pixel data of a row is on the bus |
| pix_data | output | PIX_W | Test-pattern pixel value, zero outside line_valid |

## Verification
Some properties are checked on every cycle by assertions:
- the counters stay within the current row length and frame height;
- the captured configuration changes only at the frame start;
- line_valid stays nested inside frame_valid, and frame_valid falls together with line_valid;
- the data bus is quiet in blanking;
- the sequencer is parked while a snapshot has not been triggered.

Other behaviour can only be shown by the bench's scenarios, which compare the exact cycle of every strobe edge and every pixel value against arithmetic expectations. These cover the blanking and skip settings, back-to-back frames, a configuration change applied mid-frame, a reset during readout, and a triggered frame followed by a trigger that must be ignored.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_SKIP = 1'b1
  } col_mode_e;

endpackage

// File: rtl/srg_cfg_latch.sv
module srg_cfg_latch #(
  parameter int HB_W = 10,
  parameter int VB_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [HB_W-1:0]         hblank,
  input  logic [VB_W-1:0]         vblank,
  input  logic                    col_skip,
  output logic [HB_W-1:0]         hb_eff,
  output logic [VB_W-1:0]         vb_eff,
  output srg_pkg::col_mode_e      mode
);

  logic [HB_W-1:0] hb_clamped;
  logic [VB_W-1:0] vb_clamped;

  always_comb begin
    hb_clamped = (hblank == '0) ? HB_W'(1) : hblank;
    vb_clamped = (vblank == '0) ? VB_W'(1) : vblank;
  end

  // settings are sampled only while the scan sits at the frame start
  always_ff @(posedge clk) begin
    if (rst || load) begin
      hb_eff <= hb_clamped;
      vb_eff <= vb_clamped;
      mode   <= col_skip ? srg_pkg::MODE_SKIP : srg_pkg::MODE_FULL;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(hb_eff) && $stable(vb_eff) && $stable(mode))); // R10
  AST_BLANK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (hb_eff != '0 && vb_eff != '0)); // R2

endmodule

// File: rtl/srg_scan_ctr.sv
module srg_scan_ctr #(
  parameter int CW = 12,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic [CW-1:0] row_len,
  input  logic [RW-1:0] frame_rows,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          at_start
);

  logic row_last;
  logic frame_last;

  assign row_last   = (col == row_len - CW'(1));
  assign frame_last = (row == frame_rows - RW'(1));
  assign at_start   = (col == '0) && (row == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (advance) begin
      if (row_last) begin
        col <= '0;
        row <= frame_last ? '0 : row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    col < row_len); // R2
  AST_ROW_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    row < frame_rows); // R3
  AST_PARKED: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(col) && $stable(row))); // R8

endmodule

// File: rtl/srg_pixel_src.sv
module srg_pixel_src #(
  parameter int ACT_ROWS  = 1024,
  parameter int DARK_COLS = 16,
  parameter int DARK_ROWS = 8,
  parameter int PIX_W     = 10,
  parameter int CW        = 12,
  parameter int RW        = 12,
  parameter int VB_W      = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      col,
  input  logic [RW-1:0]      row,
  input  logic [CW-1:0]      act_out,
  input  logic [VB_W-1:0]    vb_eff,
  input  srg_pkg::col_mode_e mode,
  output logic               fv,
  output logic               lv,
  output logic [PIX_W-1:0]   pix
);

  localparam logic [PIX_W-1:0] ORIGIN = PIX_W'(DARK_ROWS + DARK_COLS);

  logic [RW-1:0]    vb_w;
  logic [RW-1:0]    arow;
  logic [CW-1:0]    pcol;
  logic             row_active;
  logic             last_row;
  logic             lv_c;
  logic             fv_c;
  logic [PIX_W-1:0] pix_c;

  always_comb begin
    vb_w       = RW'(vb_eff);
    row_active = (row >= vb_w);
    arow       = row - vb_w;
    last_row   = row_active && (arow == RW'(ACT_ROWS - 1));
    lv_c       = row_active && (col < act_out);
    fv_c       = row_active && !(last_row && (col >= act_out));
    if (mode == srg_pkg::MODE_SKIP)
      pcol = ((col >> 1) << 2) | (col & CW'(1));
    else
      pcol = col;
    pix_c = ORIGIN + PIX_W'(arow) + PIX_W'(pcol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fv  <= 1'b0;
      lv  <= 1'b0;
      pix <= '0;
    end else begin
      fv  <= fv_c;
      lv  <= lv_c;
      pix <= lv_c ? pix_c : '0;
    end
  end

  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (rst)
    lv |-> fv); // R5
  AST_FV_ENDS_ON_PIXEL: assert property (@(posedge clk) disable iff (rst)
    $fell(fv) |-> $past(lv)); // R5
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lv |-> (pix == '0)); // R6

endmodule

// File: rtl/sensor_readout_gen.sv
module sensor_readout_gen #(
  parameter int ACT_COLS  = 1280,
  parameter int ACT_ROWS  = 1024,
  parameter int DARK_COLS = 16,
  parameter int DARK_ROWS = 8,
  parameter int HB_W      = 10,
  parameter int VB_W      = 11,
  parameter int PIX_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HB_W-1:0]  hblank,
  input  logic [VB_W-1:0]  vblank,
  input  logic             col_skip,
  input  logic             snap_mode,
  input  logic             trigger,
  output logic             frame_valid,
  output logic             line_valid,
  output logic [PIX_W-1:0] pix_data
);

  localparam int CW = $clog2(ACT_COLS + (1 << HB_W) + 1);
  localparam int RW = $clog2(ACT_ROWS + (1 << VB_W) + 1);

  logic [HB_W-1:0]    hb_eff;
  logic [VB_W-1:0]    vb_eff;
  srg_pkg::col_mode_e mode;
  logic [CW-1:0]      col;
  logic [RW-1:0]      row;
  logic               at_start;
  logic               advance;
  logic [CW-1:0]      act_out;
  logic [CW-1:0]      row_len;
  logic [RW-1:0]      frame_rows;

  always_comb begin
    act_out    = (mode == srg_pkg::MODE_SKIP) ? CW'(ACT_COLS / 2) : CW'(ACT_COLS);
    row_len    = act_out + CW'(hb_eff);
    frame_rows = RW'(ACT_ROWS) + RW'(vb_eff);
    advance    = !(at_start && snap_mode && !trigger);
  end

  srg_cfg_latch #(.HB_W(HB_W), .VB_W(VB_W)) u_cfg (
    .clk(clk), .rst(rst), .load(at_start),
    .hblank(hblank), .vblank(vblank), .col_skip(col_skip),
    .hb_eff(hb_eff), .vb_eff(vb_eff), .mode(mode)
  );

  srg_scan_ctr #(.CW(CW), .RW(RW)) u_scan (
    .clk(clk), .rst(rst), .advance(advance),
    .row_len(row_len), .frame_rows(frame_rows),
    .col(col), .row(row), .at_start(at_start)
  );

  srg_pixel_src #(
    .ACT_ROWS(ACT_ROWS), .DARK_COLS(DARK_COLS), .DARK_ROWS(DARK_ROWS),
    .PIX_W(PIX_W), .CW(CW), .RW(RW), .VB_W(VB_W)
  ) u_pix (
    .clk(clk), .rst(rst), .col(col), .row(row), .act_out(act_out),
    .vb_eff(vb_eff), .mode(mode),
    .fv(frame_valid), .lv(line_valid), .pix(pix_data)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!frame_valid && !line_valid && pix_data == '0)); // R1
  AST_SNAP_WAIT: assert property (@(posedge clk) disable iff (rst)
    (at_start && snap_mode && !trigger) |=> at_start); // R8
  AST_VIDEO_RUNS: assert property (@(posedge clk) disable iff (rst)
    (at_start && !snap_mode) |=> !at_start); // R9

endmodule

// File: tb/sim_sensor_readout_gen.sv
`timescale 1ns/1ps
module sim_sensor_readout_gen;

  localparam int AC = 8, AR = 4, DC = 2, DR = 1, HBW = 3, VBW = 2, PW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HBW-1:0] hblank = '0;
  logic [VBW-1:0] vblank = '0;
  logic col_skip = 1'b0, snap_mode = 1'b0, trigger = 1'b0;
  logic frame_valid, line_valid;
  logic [PW-1:0] pix_data;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  sensor_readout_gen #(.ACT_COLS(AC), .ACT_ROWS(AR), .DARK_COLS(DC),
    .DARK_ROWS(DR), .HB_W(HBW), .VB_W(VBW), .PIX_W(PW)) u0 (
    .clk(clk), .rst(rst), .hblank(hblank), .vblank(vblank),
    .col_skip(col_skip), .snap_mode(snap_mode), .trigger(trigger),
    .frame_valid(frame_valid), .line_valid(line_valid), .pix_data(pix_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rt_of(input int hb, input int sk);
    return (sk != 0 ? AC/2 : AC) + (hb < 1 ? 1 : hb);
  endfunction

  function automatic int ft_of(input int hb, input int vb, input int sk);
    return (AR + (vb < 1 ? 1 : vb)) * rt_of(hb, sk);
  endfunction

  function automatic void model(input int p, input int hb, input int vb, input int sk,
                                output bit efv, output bit elv, output int epx);
    int vbe = (vb < 1) ? 1 : vb;
    int ao  = (sk != 0) ? AC/2 : AC;
    int rl  = rt_of(hb, sk);
    int r = p / rl, c = p % rl, pc;
    bit act = (r >= vbe);
    elv = act && (c < ao);
    efv = act && !((r == vbe + AR - 1) && (c >= ao));
    pc  = (sk != 0) ? ((c / 2) * 4 + (c % 2)) : c;
    epx = elv ? ((DR + (r - vbe) + DC + pc) % (1 << PW)) : 0;
  endfunction

  // t=1 is the first negedge after the edge that starts the frame (p = t-1)
  task automatic follow(input int hb1, input int vb1, input int sk1,
                        input int hb2, input int vb2, input int sk2,
                        input int sw, input bit single, input int tpulse,
                        input int ncyc, input string tag);
    int ft1 = ft_of(hb1, vb1, sk1);
    int ft2 = ft_of(hb2, vb2, sk2);
    for (int t = 1; t <= ncyc; t++) begin
      bit efv, elv;
      int epx;
      int p = t - 1;
      @(negedge clk);
      if (t == 1) trigger = 1'b0;
      if (t == sw) begin
        hblank = HBW'(hb2); vblank = VBW'(vb2); col_skip = (sk2 != 0);
      end
      if (t == tpulse) trigger = 1'b1;
      if (t == tpulse + 1) trigger = 1'b0;
      if (p < ft1) model(p, hb1, vb1, sk1, efv, elv, epx);
      else if (single) begin efv = 0; elv = 0; epx = 0; end
      else model((p - ft1) % ft2, hb2, vb2, sk2, efv, elv, epx);
      chk(frame_valid == efv, {tag, " frame_valid"}, int'(frame_valid), int'(efv));
      chk(line_valid == elv,  {tag, " line_valid"},  int'(line_valid),  int'(elv));
      chk(int'(pix_data) == epx, {tag, " pix_data"}, int'(pix_data), epx);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic set_cfg(input int hb, input int vb, input int sk);
    hblank = HBW'(hb); vblank = VBW'(vb); col_skip = (sk != 0);
  endtask

  initial begin
    int ft, guard;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!frame_valid && !line_valid && pix_data == '0, "R1 reset state",
        int'({frame_valid, line_valid}), 0);

    // sweep of blanking and skip settings, two frames each (R1 R2 R3 R4 R5 R6 R7 R9)
    for (int hb = 0; hb < 8; hb++)
      for (int vb = 0; vb < 4; vb++)
        for (int sk = 0; sk < 2; sk++) begin
          set_cfg(hb, vb, sk);
          do_reset();
          follow(hb, vb, sk, hb, vb, sk, 0, 0, 0, 2 * ft_of(hb, vb, sk) + 3,
                 "R1 R2 R3 R4 R5 R6 R7 R9 sweep");
        end

    // R10: settings changed mid-frame apply to the next frame only
    set_cfg(2, 1, 0);
    do_reset();
    ft = ft_of(2, 1, 0);
    follow(2, 1, 0, 5, 3, 1, ft / 2, 0, 0, ft + 2 * ft_of(5, 3, 1) + 3, "R10 deferred cfg");

    // R1: reset in the middle of a line
    set_cfg(1, 1, 0);
    do_reset();
    guard = 0;
    while (!line_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(line_valid == 1'b1, "R1 line reached", int'(line_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!frame_valid && !line_valid && pix_data == '0, "R1 mid-line reset",
        int'({frame_valid, line_valid}) + int'(pix_data), 0);
    @(negedge clk); rst = 1'b0;
    follow(1, 1, 0, 1, 1, 0, 0, 0, 0, ft_of(1, 1, 0) + 2, "R1 restart");

    // R8: snapshot waits, one frame per trigger, mid-frame trigger ignored
    snap_mode = 1'b1;
    set_cfg(2, 1, 1);
    do_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(!frame_valid && !line_valid, "R8 waiting", int'({frame_valid, line_valid}), 0);
    end
    trigger = 1'b1;
    ft = ft_of(2, 1, 1);
    follow(2, 1, 1, 2, 1, 1, 0, 1, ft / 2, 4 * ft, "R8 single frame");
    trigger = 1'b1;
    follow(2, 1, 1, 2, 1, 1, 0, 1, 0, 2 * ft, "R8 second trigger");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule